// File: doc/BRIEF.md
# Serial PHY Management Bridge

This block lets software reach the registers of an external Ethernet PHY through a single 32-bit access word. One write to the word selects a 5-bit PHY register and a 16-bit value. The same write also sets a direction flag. The bridge then sends a complete Clause 22 management frame on the MDC clock and the MDIO data line. Every frame targets one fixed PHY address, which defaults to 1.

The flag also reports completion, and its sense depends on the direction:

- **Write:** software starts the transfer with the flag set. The bridge clears the flag once the last bit has been clocked out.
- **Read:** software starts the transfer with the flag clear. The bridge sets the flag once the 16 returned bits sit in the low half of the word.

Software polls the word until the flag has flipped.

MDC is made from the system clock by a counter with a parameter for the half-period. The bridge changes MDIO just after each MDC falling edge and samples it on each MDC rising edge. During a read, the bridge stops driving the line from the turnaround onward.

Top module: `mdio_access_bridge`

## Requirements
- R1: After reset the access word reads 0, MDC is low and the MDIO output enable is low.
- R2: When the bridge accepts an access with bit 31 set, it emits 64 bits MSB first. These are 32 ones, start `01`, opcode `01`, the PHY address `00001`, access-word bits 20:16, turnaround `10`, then access-word bits 15:0. The bridge drives all 64 bits.
- R3: A write completes exactly 128*DIV_HALF clock cycles after it is accepted. At that point bit 31 of the access word drops to 0, and bits 20:0 keep the written values.
- R4: When the bridge accepts an access with bit 31 clear, it emits 32 ones, `01`, opcode `10`, the PHY address and access-word bits 20:16. It drives those first 46 bits and releases MDIO (output enable low) for the 18 turnaround and data bits.
- R5: A read completes exactly 128*DIV_HALF cycles after it is accepted. At that point bit 31 becomes 1 and bits 15:0 hold the 16 bits sampled from mdio_i, first-received bit in bit 15.
- R6: MDC has a period of 2*DIV_HALF clock cycles during a transfer and is high for half of it. MDC stays low when the bridge is idle. mdio_o changes only when MDC falls.
- R7: A write to the access word while a transfer is in progress is ignored. The word's contents and the frame on the line are unaffected, and no extra frame follows.
- R8: Access-word bits 30:21 always read as 0, whatever value was written to them.
- R9: Outside a transfer the bridge does not drive MDIO (output enable low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | One-cycle write strobe for the access word |
| reg_wdata | input | 32 | Value written: bit 31 flag, 20:16 register, 15:0 data |
| reg_rdata | output | 32 | Current access word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | High while the bridge drives MDIO |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The hardest case to reach is a register write that lands in the middle of a live frame. The bridge must discard that write, yet the frame must finish with its original contents and timing, and no second frame may follow. The stimulus starts a write and, partway through the preamble, strobes a read request with a different register and data. It then checks the word during and after the transfer, the serial frame a PHY model captured, and that MDC stays low afterwards. Read data is returned by the PHY model, which counts MDC rising edges and drives each bit after the preceding falling edge.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int PRE_W    = 32;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int FRAME_W  = PRE_W + 2 + 2 + ADDR_W + ADDR_W + 2 + DATA_W;
  localparam int TA_IDX   = PRE_W + 4 + 2 * ADDR_W;
  localparam int DATA_IDX = TA_IDX + 2;
  localparam int IDX_W    = $clog2(FRAME_W);

  localparam logic [1:0] START_SEQ = 2'b01;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] reg_a,
    input logic [DATA_W-1:0] dat);
    build_frame = {{PRE_W{1'b1}}, START_SEQ, (rd ? OP_READ : OP_WRITE),
                   phy, reg_a, (rd ? 2'b11 : 2'b10),
                   (rd ? {DATA_W{1'b1}} : dat)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] TERM = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = run && (cnt == TERM);
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r6_ticks_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rise_tick && fall_tick));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] RELEASE_IDX = IDX_W'(TA_IDX - 1);
  localparam logic [IDX_W-1:0] FIRST_DATA  = IDX_W'(DATA_IDX);

  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   bit_idx;
  logic               is_rd;
  logic [DATA_W-1:0]  capture;

  assign done    = busy && fall_tick && (bit_idx == LAST_IDX);
  assign rd_data = capture;
  assign mdio_o  = frame[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      frame   <= '1;
      bit_idx <= '0;
      is_rd   <= 1'b0;
      busy    <= 1'b0;
      mdio_oe <= 1'b0;
      capture <= '0;
    end else if (start && !busy) begin
      frame   <= build_frame(start_rd, PHY_ADDR, reg_addr, wr_data);
      bit_idx <= '0;
      is_rd   <= start_rd;
      busy    <= 1'b1;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_tick && is_rd && (bit_idx >= FIRST_DATA))
        capture <= {capture[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (bit_idx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          frame   <= {frame[FRAME_W-2:0], 1'b1};
          if (is_rd && (bit_idx == RELEASE_IDX))
            mdio_oe <= 1'b0;
        end
      end
    end
  end

  a_r4_read_released: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && (bit_idx > RELEASE_IDX)) |-> !mdio_oe);
  a_r2_write_driven: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_rd) |-> mdio_oe);
endmodule

// File: rtl/mdio_access_bridge.sv
module mdio_access_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int                DIV_HALF = 4,
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FLAG_BIT = 31;
  localparam int ADDR_LO  = 16;
  localparam int PAD_W    = FLAG_BIT - ADDR_LO - ADDR_W;

  logic              busy, done, rise_tick, fall_tick, accept;
  logic [DATA_W-1:0] rd_data;
  logic [31:0]       acc;

  assign accept    = reg_wr && !busy;
  assign reg_rdata = acc;

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine #(.PHY_ADDR(PHY_ADDR)) u_eng (
    .clk(clk), .rst(rst), .start(accept),
    .start_rd(!reg_wdata[FLAG_BIT]),
    .reg_addr(reg_wdata[ADDR_LO +: ADDR_W]),
    .wr_data(reg_wdata[DATA_W-1:0]),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (accept) begin
      acc <= {reg_wdata[FLAG_BIT], {PAD_W{1'b0}},
              reg_wdata[ADDR_LO +: ADDR_W], reg_wdata[DATA_W-1:0]};
    end else if (done) begin
      if (acc[FLAG_BIT]) begin
        acc[FLAG_BIT] <= 1'b0;
      end else begin
        acc[FLAG_BIT]    <= 1'b1;
        acc[DATA_W-1:0]  <= rd_data;
      end
    end
  end

  a_r7_ignore_busy_write: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && !done) |=> (acc == $past(acc)));
  a_r3_write_flag_clears: assert property (@(posedge clk) disable iff (rst)
    (done && acc[FLAG_BIT]) |=> !acc[FLAG_BIT]);
  a_r5_read_flag_sets: assert property (@(posedge clk) disable iff (rst)
    (done && !acc[FLAG_BIT]) |=> acc[FLAG_BIT]);
  a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  a_r6_data_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));
  a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  a_r8_pad_zero: assert property (@(posedge clk) disable iff (rst)
    acc[FLAG_BIT-1 -: PAD_W] == '0);
endmodule

// File: tb/mdio_access_bridge_tb.sv
module mdio_access_bridge_tb;
  localparam int D   = 4;
  localparam int LAT = 128 * D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_vec = 0;
  int n_bad = 0;

  logic [5:0]  rise_cnt = '0;
  logic [63:0] cap_bits = '0, cap_oe = '0;
  logic [63:0] last_frame = '0, last_oe = '0;
  logic [15:0] phy_rdata = 16'h0;

  always #4 clk = ~clk;

  mdio_access_bridge #(.DIV_HALF(D), .PHY_ADDR(5'd1)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: capture bits on MDC rise, return read data after MDC fall
  always @(posedge mdc) begin
    cap_bits = {cap_bits[62:0], mdio_o};
    cap_oe   = {cap_oe[62:0], mdio_oe};
    if (rise_cnt == 6'd63) begin
      last_frame = cap_bits;
      last_oe    = cap_oe;
    end
    rise_cnt = rise_cnt + 6'd1;
  end

  always @(negedge mdc) begin
    if (rise_cnt >= 6'd48) mdio_i = phy_rdata[6'd63 - rise_cnt];
    else                   mdio_i = 1'b0;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Issue one access; optionally inject a second write mid-transfer.
  task automatic run_access(input logic [31:0] w, input bit inject,
                            input logic [31:0] w2, input logic [31:0] exp_final);
    int highs = 0;
    logic [31:0] during;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 32'hDEAD_BEEF;
    if (mdc) highs++;
    for (int i = 1; i < LAT; i++) begin
      if (inject && i == 100) begin
        reg_wr = 1'b1; reg_wdata = w2;
      end else begin
        reg_wr = 1'b0;
      end
      @(negedge clk);
      if (mdc) highs++;
      if (inject && i == 150) during = reg_rdata;
    end
    reg_wr = 1'b0;
    // now after edge accept+LAT-1: flag must still hold its start value
    check(reg_rdata[31] == w[31], w[31] ? "R3 flag early" : "R5 flag early",
          64'(reg_rdata[31]), 64'(w[31]));
    check(highs == LAT / 2, "R6 mdc duty", 64'(highs), 64'(LAT / 2));
    if (inject)
      check(during == {w[31], 10'b0, w[20:0]}, "R7 word during busy",
            64'(during), 64'({w[31], 10'b0, w[20:0]}));
    @(negedge clk);
    check(reg_rdata == exp_final, w[31] ? "R3 write done" : "R5 read done",
          64'(reg_rdata), 64'(exp_final));
    check(!mdio_oe, "R9 released after", 64'(mdio_oe), 64'(0));
  endtask

  task automatic t_reset();
    check(reg_rdata == 32'h0, "R1 word", 64'(reg_rdata), 64'(0));
    check(!mdc, "R1 mdc", 64'(mdc), 64'(0));
    check(!mdio_oe, "R1 oe", 64'(mdio_oe), 64'(0));
  endtask

  task automatic t_write(input logic [4:0] ra, input logic [15:0] dat,
                         input logic [9:0] junk);
    logic [63:0] exp_f;
    logic [31:0] w;
    w = {1'b1, junk, ra, dat};
    exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, ra, 2'b10, dat};
    run_access(w, 1'b0, '0, {1'b0, 10'b0, ra, dat});
    check(last_frame == exp_f, "R2 write frame", last_frame, exp_f);
    check(last_oe == '1, "R2 write drive", last_oe, '1);
  endtask

  task automatic t_read(input logic [4:0] ra, input logic [15:0] phyv,
                        input logic [15:0] wdat);
    logic [45:0] exp_h;
    phy_rdata = phyv;
    exp_h = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd1, ra};
    run_access({1'b0, 10'h3FF, ra, wdat}, 1'b0, '0, {1'b1, 10'b0, ra, phyv});
    check(last_frame[63:18] == exp_h, "R4 read header",
          64'(last_frame[63:18]), 64'(exp_h));
    check(last_oe == {{46{1'b1}}, 18'b0}, "R4 release pattern",
          last_oe, {{46{1'b1}}, 18'b0});
  endtask

  task automatic t_busy_ignore();
    logic [31:0] w;
    logic [63:0] exp_f;
    w = {1'b1, 10'b0, 5'd3, 16'h1111};
    exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, 5'd3, 2'b10, 16'h1111};
    run_access(w, 1'b1, {1'b0, 10'b0, 5'd7, 16'h2222}, {1'b0, 10'b0, 5'd3, 16'h1111});
    check(last_frame == exp_f, "R7 frame untouched", last_frame, exp_f);
    repeat (4 * LAT) @(negedge clk);
    check(!mdc && rise_cnt == 6'd0, "R7 no extra frame",
          64'({mdc, rise_cnt}), 64'(0));
    check(reg_rdata == {1'b0, 10'b0, 5'd3, 16'h1111}, "R7 word kept",
          64'(reg_rdata), 64'({1'b0, 10'b0, 5'd3, 16'h1111}));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(5'h0B, 16'hA5C3, 10'h000);
    t_write(5'h1F, 16'h0001, 10'h3FF);      // R8 pad bits written as ones
    t_read(5'h02, 16'h3C96, 16'h1234);
    t_read(5'h10, 16'h8001, 16'hFFFF);
    t_busy_ignore();
    check(!mdio_oe && !mdc, "R9 idle line", 64'({mdio_oe, mdc}), 64'(0));
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule